// File: doc/BRIEF.md
# Binary-Digit Character Serializer

This block takes a 16-bit word and turns it into a stream of ASCII digit characters, one for each bit, with the most significant bit first. A one-cycle load request captures the word when the block is idle. The block then offers one character at a time on a byte output with valid/ready flow control. The character is `'1'` (31h) or `'0'` (30h).

Each accepted character rotates the working register left by one place. The bit that leaves the top position is the bit that chose the character just sent, and it re-enters at the bottom. After the sixteenth accepted character the register holds the loaded word again. At that point the block goes idle and pulses a completion flag.

Top module: `bin_ascii_ser`

## Requirements
- R1: After reset, busy, character-valid and done are all low and the word output is 0000h.
- R2: A load request seen while idle captures `data_i` into the word output and raises busy in the next cycle.
- R3: Character-valid is high exactly in the cycles in which busy is high.
- R4: While valid, the character output is 31h when bit 15 of the word output is 1 and 30h when it is 0.
- R5: The k-th accepted character (k = 0..15) of a word shows bit 15-k of the loaded word, so the digits come out most significant first.
- R6: The register rotates left by one and the step count advances only in a cycle where valid and ready are both high. While valid is high and ready is low, the character and the word stay unchanged.
- R7: Exactly 16 characters are accepted per load, and busy falls in the cycle after the sixteenth acceptance.
- R8: Done is high for exactly one cycle, the cycle after the sixteenth acceptance.
- R9: Once the word has been fully sent, the word output equals the loaded value.
- R10: A load request while busy has no effect on the word, the character sequence or the count.
- R11: Loading 0006h gives thirteen 30h characters followed by 31h, 31h, 30h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load request; taken only while idle |
| data_i | input | 16 | Word to serialize |
| char_o | output | 8 | ASCII digit character |
| char_valid_o | output | 1 | Character is offered |
| char_ready_i | input | 1 | Consumer accepts the character this cycle |
| busy_o | output | 1 | Serialization in progress |
| done_o | output | 1 | One-cycle pulse after the last character |
| word_o | output | 16 | Current contents of the rotating register |

## Verification
The assertions assume that `char_ready_i` and `load_i` are clean, defined levels that are sampled at the clock edge. They also assume that a consumer may hold ready low for any number of cycles, and the stall property depends on that. The bench therefore changes every input only on the falling edge. It mixes steady ready with stall patterns that hold ready low for one or several cycles. It also raises load with different data in the middle of a word, so that the ignore rule and the hold rule are both exercised under these assumptions.

// File: rtl/bas_pkg.sv
package bas_pkg;
   typedef logic [7:0] char_t;

   function automatic char_t pick_char(input logic bit_v, input char_t one_c, input char_t zero_c);
      return bit_v ? one_c : zero_c;
   endfunction
endpackage

// File: rtl/bas_rot_reg.sv
module bas_rot_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_go,
   input  logic              step,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] word_q,
   output logic              top_bit
);
   logic [DATA_W-1:0] rot_next;

   // rotate left: position i takes the bit below it, bit 0 takes the top bit
   for (genvar i = 0; i < DATA_W; i++) begin : g_rot
      if (i == 0) begin : g_wrap
         assign rot_next[i] = word_q[DATA_W-1];
      end else begin : g_mid
         assign rot_next[i] = word_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load_go) begin
         word_q <= load_val;
      end else if (step) begin
         word_q <= rot_next;
      end
   end

   assign top_bit = word_q[DATA_W-1];
endmodule

// File: rtl/bas_step_cnt.sv
module bas_step_cnt #(
   parameter int DATA_W = 16,
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_go,
   input  logic step,
   output logic busy,
   output logic done
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0] idx_q;
   logic             last;

   assign last = (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         idx_q <= '0;
      end else begin
         done <= step && last;
         if (load_go) begin
            busy  <= 1'b1;
            idx_q <= '0;
         end else if (step) begin
            idx_q <= idx_q + 1'b1;
            if (last) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bas_char_map.sv
module bas_char_map
   import bas_pkg::*;
#(
   parameter char_t CHAR_ONE  = 8'h31,
   parameter char_t CHAR_ZERO = 8'h30
) (
   input  logic  bit_i,
   output char_t char_o
);
   assign char_o = pick_char(bit_i, CHAR_ONE, CHAR_ZERO);
endmodule

// File: rtl/bin_ascii_ser.sv
module bin_ascii_ser
   import bas_pkg::*;
#(
   parameter int    DATA_W    = 16,
   parameter char_t CHAR_ONE  = 8'h31,
   parameter char_t CHAR_ZERO = 8'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [7:0]        char_o,
   output logic              char_valid_o,
   input  logic              char_ready_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] word_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("bin_ascii_ser: DATA_W must be at least 2");
   end
   if (CHAR_ONE == CHAR_ZERO) begin : g_bad_chars
      $error("bin_ascii_ser: digit characters must differ");
   end

   logic load_go;
   logic step;
   logic top_bit;

   assign load_go = load_i && !busy_o;
   assign step    = busy_o && char_ready_i;

   bas_rot_reg #(.DATA_W(DATA_W)) rot_i (
      .clk(clk), .rst_n(rst_n), .load_go(load_go), .step(step),
      .load_val(data_i), .word_q(word_o), .top_bit(top_bit)
   );

   bas_step_cnt #(.DATA_W(DATA_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load_go(load_go), .step(step),
      .busy(busy_o), .done(done_o)
   );

   bas_char_map #(.CHAR_ONE(CHAR_ONE), .CHAR_ZERO(CHAR_ZERO)) map_i (
      .bit_i(top_bit), .char_o(char_o)
   );

   assign char_valid_o = busy_o;
endmodule

// File: rtl/bin_ascii_ser_chk.sv
module bin_ascii_ser_chk #(
   parameter int         DATA_W    = 16,
   parameter logic [7:0] CHAR_ONE  = 8'h31,
   parameter logic [7:0] CHAR_ZERO = 8'h30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [DATA_W-1:0] data_i,
   input logic [7:0]        char_o,
   input logic              char_valid_o,
   input logic              char_ready_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] word_o
);
   localparam int AW = $clog2(DATA_W + 1) + 1;
   logic [AW-1:0] acc_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_cnt <= '0;
      else if (!busy_o && load_i) acc_cnt <= '0;
      else if (char_valid_o && char_ready_i) acc_cnt <= acc_cnt + 1'b1;
   end

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && load_i |=> busy_o && word_o == $past(data_i));
   // R4
   char_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid_o |-> char_o == (word_o[DATA_W-1] ? CHAR_ONE : CHAR_ZERO));
   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid_o && !char_ready_i |=> char_valid_o && $stable(word_o) && $stable(char_o));
   // R10
   busy_load_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && load_i && char_ready_i |=>
         word_o == {$past(word_o[DATA_W-2:0]), $past(word_o[DATA_W-1])});
   // R7
   done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && acc_cnt == AW'(DATA_W));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

bind bin_ascii_ser bin_ascii_ser_chk #(
   .DATA_W(DATA_W), .CHAR_ONE(CHAR_ONE), .CHAR_ZERO(CHAR_ZERO)
) chk_i (.*);

// File: tb/bin_ascii_ser_tb_top.sv
module bin_ascii_ser_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [15:0] data_i = '0;
   logic        char_ready_i = 1'b0;
   logic [7:0]  char_o;
   logic        char_valid_o, busy_o, done_o;
   logic [15:0] word_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // behavioural model state
   bit          m_busy = 0, m_done = 0;
   logic [15:0] m_word = '0;
   int          m_idx = 0;
   string       sent = "";

   always #5 clk = ~clk;

   bin_ascii_ser dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
      .char_o(char_o), .char_valid_o(char_valid_o), .char_ready_i(char_ready_i),
      .busy_o(busy_o), .done_o(done_o), .word_o(word_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare, advance model, wait for edge
   task automatic cyc(input bit ld, input logic [15:0] d, input bit rdy);
      logic [7:0] exp_c;
      @(negedge clk);
      load_i = ld; data_i = d; char_ready_i = rdy;
      #1;
      exp_c = m_word[15] ? 8'h31 : 8'h30;
      chk(busy_o == m_busy, "R7 busy", busy_o, m_busy);
      chk(char_valid_o == m_busy, "R3 valid", char_valid_o, m_busy);
      chk(done_o == m_done, "R8 done", done_o, m_done);
      chk(word_o == m_word, "R6 word", word_o, m_word);
      if (m_busy) chk(char_o == exp_c, "R4 char", char_o, exp_c);
      if (!m_busy && ld) begin
         m_word = d; m_idx = 0; m_busy = 1; m_done = 0; sent = "";
      end else if (m_busy && rdy) begin
         sent = {sent, string'(char_o)};
         m_word = {m_word[14:0], m_word[15]};
         m_idx++;
         m_done = (m_idx == 16);
         if (m_done) m_busy = 0;
      end else begin
         m_done = 0;
      end
   endtask

   function automatic string bits_str(input logic [15:0] v);
      string s = "";
      for (int k = 15; k >= 0; k--) s = {s, v[k] ? "1" : "0"};
      return s;
   endfunction

   // send one word; stall_mode 0 = always ready, 1 = alternating, 2 = long stalls and loads while busy
   task automatic send_word(input logic [15:0] v, input int stall_mode);
      int n = 0;
      cyc(1'b1, v, 1'b0);
      cyc(1'b0, 16'h0, 1'b0);
      chk(word_o == v && busy_o, "R2 load", word_o, v);
      while (m_busy && n < 200) begin
         bit r;
         case (stall_mode)
            0: r = 1;
            1: r = n[0];
            default: r = (n % 4 == 3);
         endcase
         cyc(stall_mode == 2, ~v, r);
         n++;
      end
      cyc(1'b0, 16'h0, 1'b0);
      chk(sent == bits_str(v), "R5 order", 32'(sent.len()), 32'd16);
      chk(sent.len() == 16, "R7 count", 32'(sent.len()), 32'd16);
      chk(word_o == v, "R9 restore", word_o, v);
      if (stall_mode == 2) chk(word_o == v, "R10 ignored", word_o, v);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(!busy_o && !char_valid_o && !done_o && word_o == 0, "R1 reset",
          {busy_o, char_valid_o, done_o, word_o}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      send_word(16'h0006, 0);
      chk(sent == "0000000000000110", "R11 sequence", 32'(sent.len()), 32'd16);
      send_word(16'hA5C3, 1);
      send_word(16'h8001, 2);
      send_word(16'hFFFF, 0);
      send_word(16'h0000, 1);
      send_word(16'h1234, 2);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R7 watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule